// File: doc/BRIEF.md
# Hall Sequence Direction Detector

This block works out which way a three-phase rotor is actually turning by watching its three position-sensor lines, which are assumed to be synchronised to the block clock already. With 120-degree sensor spacing the three lines form a six-code cycle, and every valid code has exactly two legal neighbours: one reached when turning forward and one reached when turning in reverse. Each time the code changes, the block checks which neighbour appeared and updates a registered direction bit to match.

Changes that cannot come from a real rotor are rejected. These are a move into or out of the all-zero or all-one code, or a jump of two or more positions. The direction bit keeps its value, and an error flag goes high for one clock for each such change. The flag can be removed through a parameter. After reset the block has no reference position. It waits for the first valid code and uses it only as that reference.

Top module: `hall_dir_detect`

## Requirements
- R1: While reset is low and in the first cycle after it, `dir_fwd` is 0 and `step_err` is 0.
- R2: A change from one valid code to the next code of the forward cycle sets `dir_fwd` to 1 in the cycle after the clock edge that samples the new code. The input `hall_abc` carries sensor A in bit 2, B in bit 1 and C in bit 0. The forward cycle is 101, 001, 011, 010, 110, 100, and then back to 101.
- R3: A change to the previous code of the forward cycle (the reverse order 101, 100, 110, 010, 011, 001) clears `dir_fwd` to 0 in the same cycle in which R2 would have set it.
- R4: When the sampled code equals the code sampled one clock earlier, `dir_fwd` holds its value and `step_err` is 0.
- R5: Once a valid reference exists, a change of code into or out of 000 or 111 leaves `dir_fwd` unchanged and raises `step_err` in the next cycle.
- R6: A change between two valid codes that are not neighbours in the cycle (two or three positions apart) leaves `dir_fwd` unchanged and raises `step_err` in the next cycle.
- R7: After reset, the first valid code only becomes the reference. It does not change `dir_fwd` and does not raise `step_err`. No change before that point raises `step_err`.
- R8: `step_err` stays high for exactly one cycle per rejected change. It drops as soon as the code is held.
- R9: The wrap between codes 100 and 101 counts as a legal step: 100 to 101 is forward and 101 to 100 is reverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hall_abc | input | 3 | Synchronised sensor code, A in bit 2, C in bit 0 |
| dir_fwd | output | 1 | Registered rotation direction, 1 = forward cycle |
| step_err | output | 1 | One-cycle pulse per rejected code change |

## Verification
Directed runs walk the full forward cycle, including the 100 to 101 wrap, and then step back across the wrap in reverse. This shows that both neighbours of every code are decoded with the right sense. Further directed steps go into and out of 111, hold on an invalid code, and make two-position jumps. These separate the rejected cases from legal steps and show that the error pulse ends after one cycle. A random walk with a fixed seed mixes legal steps in both directions, held codes and arbitrary codes. This exercises direction reversals at every position, and it also covers invalid codes that arrive before the reference exists.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  localparam int HSD_STATES = 6;
  localparam int HSD_CODE_W = 3;

  typedef logic [HSD_CODE_W-1:0] hall_t;

  // Position of a code inside the forward cycle; 7 marks an unusable code
  function automatic logic [2:0] hsd_pos(hall_t c);
    case (c)
      3'b101:  return 3'd0;
      3'b001:  return 3'd1;
      3'b011:  return 3'd2;
      3'b010:  return 3'd3;
      3'b110:  return 3'd4;
      3'b100:  return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic hsd_ok(hall_t c);
    return (c != 3'b000) && (c != 3'b111);
  endfunction
endpackage

// File: rtl/hsd_decode.sv
module hsd_decode
  import hsd_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  hall_t            code,
  output logic [IDX_W-1:0] idx,
  output logic             ok
);
  logic [2:0] pos;

  always_comb begin
    pos = hsd_pos(code);
    ok  = hsd_ok(code);
    idx = ok ? IDX_W'(pos) : '0;
  end
endmodule

// File: rtl/hsd_step_cmp.sv
module hsd_step_cmp #(
  parameter int N_POS = 6,
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] old_idx,
  input  logic             old_ok,
  input  logic [IDX_W-1:0] new_idx,
  input  logic             new_ok,
  output logic             fwd,
  output logic             rev
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_POS - 1);

  logic [IDX_W-1:0] succ_idx;
  logic [IDX_W-1:0] pred_idx;

  always_comb begin
    succ_idx = (old_idx == LAST) ? '0 : old_idx + 1'b1;
    pred_idx = (old_idx == '0) ? LAST : old_idx - 1'b1;
    fwd = old_ok && new_ok && (new_idx == succ_idx);
    rev = old_ok && new_ok && (new_idx == pred_idx);
  end
endmodule

// File: rtl/hall_dir_detect.sv
module hall_dir_detect
  import hsd_pkg::*;
#(
  parameter bit FLAG_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_abc,
  output logic       dir_fwd,
  output logic       step_err
);
  localparam int IDX_W = $clog2(HSD_STATES);

  hall_t            last_code;
  logic             seen;
  logic             dir_q;
  logic [IDX_W-1:0] cur_idx, old_idx;
  logic             cur_ok, old_ok;
  logic             is_fwd, is_rev;
  logic             changed;
  logic             reject;

  hsd_decode #(.IDX_W(IDX_W)) u_dec_cur (
    .code(hall_abc), .idx(cur_idx), .ok(cur_ok)
  );

  hsd_decode #(.IDX_W(IDX_W)) u_dec_old (
    .code(last_code), .idx(old_idx), .ok(old_ok)
  );

  hsd_step_cmp #(.N_POS(HSD_STATES), .IDX_W(IDX_W)) u_cmp (
    .old_idx(old_idx), .old_ok(old_ok),
    .new_idx(cur_idx), .new_ok(cur_ok),
    .fwd(is_fwd), .rev(is_rev)
  );

  always_comb begin
    changed = (hall_abc != last_code);
    reject  = seen && changed && !(is_fwd || is_rev);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_code <= '0;
      seen      <= 1'b0;
      dir_q     <= 1'b0;
    end else begin
      last_code <= hall_abc;
      if (!seen && cur_ok) seen <= 1'b1;
      if (seen && changed && is_fwd)      dir_q <= 1'b1;
      else if (seen && changed && is_rev) dir_q <= 1'b0;
    end
  end

  assign dir_fwd = dir_q;

  generate
    if (FLAG_EN) begin : g_flag
      logic err_q;
      always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= reject;
      end
      assign step_err = err_q;
    end else begin : g_noflag
      assign step_err = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/hall_dir_detect_chk.sv
module hall_dir_detect_chk
  import hsd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] hall_abc,
  input logic       dir_fwd,
  input logic       step_err
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  function automatic hall_t nxt(hall_t c);
    case (c)
      3'b101:  return 3'b001;
      3'b001:  return 3'b011;
      3'b011:  return 3'b010;
      3'b010:  return 3'b110;
      3'b110:  return 3'b100;
      3'b100:  return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  function automatic hall_t prv(hall_t c);
    case (c)
      3'b101:  return 3'b100;
      3'b100:  return 3'b110;
      3'b110:  return 3'b010;
      3'b010:  return 3'b011;
      3'b011:  return 3'b001;
      3'b001:  return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!dir_fwd && !step_err));

  p_fwd_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && hsd_ok($past(hall_abc)) && (hall_abc == nxt($past(hall_abc)))
    |=> dir_fwd);

  p_rev_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && hsd_ok($past(hall_abc)) && (hall_abc == prv($past(hall_abc)))
    |=> !dir_fwd);

  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && (hall_abc == $past(hall_abc))
    |=> ($stable(dir_fwd) && !step_err));

  p_enter_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && hsd_ok($past(hall_abc)) && !hsd_ok(hall_abc)
    |=> (step_err && $stable(dir_fwd)));

  p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && hsd_ok($past(hall_abc)) && hsd_ok(hall_abc)
    && (hall_abc != $past(hall_abc))
    && (hall_abc != nxt($past(hall_abc)))
    && (hall_abc != prv($past(hall_abc)))
    |=> (step_err && $stable(dir_fwd)));
endmodule

bind hall_dir_detect hall_dir_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hall_abc(hall_abc),
  .dir_fwd(dir_fwd), .step_err(step_err)
);

// File: tb/sim_hall_dir_detect.sv
`timescale 1ns/1ps
module sim_hall_dir_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall_abc = 3'b000;
  logic       dir_fwd;
  logic       step_err;

  int n_cmp = 0;
  int n_bad = 0;

  // model state
  logic       m_dir = 1'b0;
  logic       m_err = 1'b0;
  logic       m_seen = 1'b0;
  logic [2:0] m_last = 3'b000;
  string      m_tag = "R1";

  localparam logic [2:0] SEQ [6] = '{3'b101, 3'b001, 3'b011, 3'b010, 3'b110, 3'b100};

  always #5 clk = ~clk;

  hall_dir_detect u0 (
    .clk(clk), .rst_n(rst_n), .hall_abc(hall_abc),
    .dir_fwd(dir_fwd), .step_err(step_err)
  );

  function automatic int bpos(logic [2:0] c);
    for (int i = 0; i < 6; i++) if (SEQ[i] == c) return i;
    return -1;
  endfunction

  // Apply the requirement rules to one new sampled code
  function automatic void model(logic [2:0] c);
    int po, pn;
    po = bpos(m_last);
    pn = bpos(c);
    m_err = 1'b0;
    if (c == m_last) begin
      m_tag = "R4";
    end else if (!m_seen) begin
      m_tag = "R7";
      if (pn >= 0) m_seen = 1'b1;
    end else if (po < 0 || pn < 0) begin
      m_tag = "R5";
      m_err = 1'b1;
    end else if (pn == (po + 1) % 6) begin
      m_tag = (po == 5) ? "R9" : "R2";
      m_dir = 1'b1;
    end else if (pn == (po + 5) % 6) begin
      m_tag = (po == 0) ? "R9" : "R3";
      m_dir = 1'b0;
    end else begin
      m_tag = "R6";
      m_err = 1'b1;
    end
    m_last = c;
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [2:0] c);
    hall_abc = c;
    model(c);
    @(negedge clk);
    chk(m_tag, "dir_fwd", dir_fwd, m_dir);
    chk(m_tag, "step_err", step_err, m_err);
    // R8: a held code always ends any error pulse
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int r;
    logic [2:0] c;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", "dir_fwd in reset", dir_fwd, 1'b0);
    chk("R1", "step_err in reset", step_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "dir_fwd after reset", dir_fwd, 1'b0);
    chk("R1", "step_err after reset", step_err, 1'b0);

    // R7 invalid before reference, then first valid code
    step(3'b111);
    step(3'b101);
    // R2 full forward cycle, R9 wrap 100 -> 101
    step(3'b001); step(3'b011); step(3'b010); step(3'b110); step(3'b100);
    step(3'b101);
    step(3'b101);               // R4 hold
    step(3'b100);               // R9 reverse wrap
    step(3'b110);               // R3
    step(3'b111);               // R5 into invalid
    step(3'b111);               // R8 pulse ends
    step(3'b010);               // R5 out of invalid
    step(3'b110);               // R2
    step(3'b001);               // R6 jump of three
    step(3'b001);               // R8
    step(3'b010);               // R6 jump of two
    step(3'b000);               // R5
    step(3'b111);               // R5 invalid to invalid
    step(3'b101);

    for (int n = 0; n < 600; n++) begin
      r = $urandom_range(0, 9);
      if (bpos(m_last) < 0 || r == 9) c = 3'($urandom_range(0, 7));
      else if (r < 4) c = SEQ[(bpos(m_last) + 1) % 6];
      else if (r < 7) c = SEQ[(bpos(m_last) + 5) % 6];
      else c = m_last;
      step(c);
      if (n == 300) begin
        rst_n = 1'b0;
        hall_abc = 3'b000;
        @(negedge clk);
        chk("R1", "dir_fwd mid reset", dir_fwd, 1'b0);
        rst_n = 1'b1;
        m_dir = 1'b0; m_seen = 1'b0; m_last = 3'b000;
        @(negedge clk);
        chk("R1", "step_err mid reset", step_err, 1'b0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule